// File: doc/BRIEF.md
# Word Address Pointer with Page Wrap

This block keeps the internal byte address of a serial nonvolatile memory of 8192 bytes, 8 bits each. The bus front end loads it once both address bytes of a command have arrived, and pulses a step strobe after every byte that is stored or sent. The pointer keeps its value between transactions. A read that carries no address of its own therefore starts at the byte after the last one accessed.

The step rule depends on the direction of the transfer. A write step counts only the low five bits. The pointer circles inside its 32-byte page, and the page number stays fixed. A read step counts all thirteen bits, so the top address rolls to zero.

A command that loads the address and then ends without data updates the pointer and touches no memory. The next current-address read uses that loaded value.

Top module: `word_addr_ptr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_addr` becomes 0 after that edge.
- R2: A cycle with `load_en` high makes `cur_addr` equal `load_addr` after the edge. A load followed by no data steps leaves that value for the next read.
- R3: When `load_en` is high, a `wr_step` or `rd_step` in the same cycle has no effect: `cur_addr` equals `load_addr` after the edge.
- R4: A `wr_step` without a load adds 1 to `cur_addr[4:0]` modulo 32, and leaves `cur_addr[12:5]` (the page number) unchanged.
- R5: An `rd_step` without a load or a `wr_step` adds 1 to the full 13-bit `cur_addr` modulo 8192. A read step can therefore carry into the page bits, and address 8191 steps to 0.
- R6: With no load and no step, `cur_addr` holds its value.
- R7: If `wr_step` and `rd_step` are both high without a load, the write rule of R4 applies.
- R8: A `wr_step` at offset 31 of a page returns the offset to 0 in the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Load the pointer from `load_addr` |
| load_addr | input | 13 | Address assembled from the two received address bytes |
| wr_step | input | 1 | Step after a byte has been written (in-page rule) |
| rd_step | input | 1 | Step after a byte has been read (full-array rule) |
| cur_addr | output | 13 | Current word address |

## Verification
The step rules are tried from a mid-page offset, across offset 31, across a page boundary with reads, and across the top of the array. Comparing the write step and the read step at the same page edges is what separates in-page wrap from full carry. Loads combined with one or both strobes show the priority order. Idle stretches after a load-only command, and a reset in mid-stream, show that the value persists and clears.

// File: rtl/word_addr_ptr_pkg.sv
// Package word_addr_ptr_pkg
// Shared encoding for the word address pointer: which update applies in a cycle.
// Assumes nothing beyond the pointer sub-blocks importing it.
package word_addr_ptr_pkg;
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_LOAD   = 2'd1,
        UPD_PAGE   = 2'd2,
        UPD_LINEAR = 2'd3
    } upd_sel_e;
endpackage

// File: rtl/word_addr_ptr_sel.sv
// Module word_addr_ptr_sel
// Picks the single update that applies this cycle.
// Priority order: load, then write step (in-page), then read step (linear), then hold.
// Assumes strobes are synchronous to clk and last one cycle per event.
module word_addr_ptr_sel
    import word_addr_ptr_pkg::*;
(
    input  logic     load_en,
    input  logic     wr_step,
    input  logic     rd_step,
    output upd_sel_e sel
);
    // Purpose: priority decode of the three strobes.
    always_comb begin
        if (load_en)      sel = UPD_LOAD;
        else if (wr_step) sel = UPD_PAGE;
        else if (rd_step) sel = UPD_LINEAR;
        else              sel = UPD_HOLD;
    end
endmodule

// File: rtl/word_addr_ptr_next.sv
// Module word_addr_ptr_next
// Computes the two stepped candidates from the present address.
// page_next: the offset field counts modulo the page size and the page field is kept.
// lin_next:  the whole address counts modulo the array size.
// If PAGE_W covers the whole address, both rules are the same.
// Assumes PAGE_W >= 1 and PAGE_W <= ADDR_W.
module word_addr_ptr_next #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] page_next,
    output logic [ADDR_W-1:0] lin_next
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] OFF_ONE  = PAGE_W'(1);

    // Purpose: full-width increment, which wraps naturally at the top.
    always_comb lin_next = addr_q + ADDR_ONE;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            // Purpose: a single page spans the array, so the write step is the linear step.
            always_comb page_next = addr_q + ADDR_ONE;
        end else begin : g_paged
            logic [PAGE_W-1:0] off_inc;
            // Purpose: offset increment, which wraps inside the page.
            always_comb off_inc = addr_q[PAGE_W-1:0] + OFF_ONE;
            // Purpose: rejoin the kept page number with the new offset.
            always_comb page_next = {addr_q[ADDR_W-1:PAGE_W], off_inc};
        end
    endgenerate
endmodule

// File: rtl/word_addr_ptr_reg.sv
// Module word_addr_ptr_reg
// The pointer storage. It takes the candidate chosen by the selector.
// The synchronous active-low reset clears it to address zero.
module word_addr_ptr_reg
    import word_addr_ptr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_sel_e          sel,
    input  logic [ADDR_W-1:0] load_val,
    input  logic [ADDR_W-1:0] page_next,
    input  logic [ADDR_W-1:0] lin_next,
    output logic [ADDR_W-1:0] addr_q
);
    // Purpose: store the selected next address, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            unique case (sel)
                UPD_LOAD:   addr_q <= load_val;
                UPD_PAGE:   addr_q <= page_next;
                UPD_LINEAR: addr_q <= lin_next;
                default:    addr_q <= addr_q;
            endcase
        end
    end
endmodule

// File: rtl/word_addr_ptr.sv
// Module word_addr_ptr
// Internal word address pointer of a paged byte memory.
// A load takes the assembled address. A write step wraps inside the page.
// A read step wraps over the whole array. The value persists until the next load, step or reset.
// Assumes single-cycle strobes from the bus front end, in the clk domain.
module word_addr_ptr
    import word_addr_ptr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_step,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] cur_addr
);
    upd_sel_e          sel;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] page_next;
    logic [ADDR_W-1:0] lin_next;

    word_addr_ptr_sel u_sel (
        .load_en (load_en),
        .wr_step (wr_step),
        .rd_step (rd_step),
        .sel     (sel)
    );

    word_addr_ptr_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_next (
        .addr_q    (addr_q),
        .page_next (page_next),
        .lin_next  (lin_next)
    );

    word_addr_ptr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .load_val  (load_addr),
        .page_next (page_next),
        .lin_next  (lin_next),
        .addr_q    (addr_q)
    );

    // Purpose: present the stored pointer.
    always_comb cur_addr = addr_q;
endmodule

// File: rtl/word_addr_ptr_chk.sv
// Module word_addr_ptr_chk
// Port-level properties of the pointer. It is bound into every word_addr_ptr instance.
module word_addr_ptr_chk #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic              wr_step,
    input logic              rd_step,
    input logic [ADDR_W-1:0] cur_addr
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] OFF_ONE  = PAGE_W'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> cur_addr == '0); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cur_addr == $past(load_addr)); // R3
    AST_WR_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load_en) |=> cur_addr[PAGE_W-1:0] == $past(cur_addr[PAGE_W-1:0]) + OFF_ONE); // R4
    AST_WR_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load_en) |=> cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])); // R8
    AST_RD_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !wr_step && !load_en) |=> cur_addr == $past(cur_addr) + ADDR_ONE); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_step && !wr_step && !load_en) |=> $stable(cur_addr)); // R6
endmodule

bind word_addr_ptr word_addr_ptr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .wr_step   (wr_step),
    .rd_step   (rd_step),
    .cur_addr  (cur_addr)
);

// File: tb/sim_word_addr_ptr.sv
// Scoreboard bench for word_addr_ptr.
// The driver pushes the expected pointer for each driven cycle.
// The monitor pops one entry and compares it after every rising edge.
module sim_word_addr_ptr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [12:0] load_addr = '0;
    logic        wr_step = 1'b0;
    logic        rd_step = 1'b0;
    logic [12:0] cur_addr;

    typedef struct {
        logic [12:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int model = 0;

    always #5 clk = ~clk;

    word_addr_ptr u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .wr_step(wr_step), .rd_step(rd_step), .cur_addr(cur_addr)
    );

    // Monitor: compare one expected item after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (cur_addr !== it.exp) begin
                failures++;
                $display("FAIL %s cur_addr=%h expected=%h", it.req, cur_addr, it.exp);
            end
        end
    end

    // Driver: apply one cycle of stimulus and push the expected result from the requirement rules.
    task automatic drive(input bit rst, input bit ld, input int v, input bit w, input bit r, input string req);
        item_t it;
        @(negedge clk);
        rst_n = ~rst; load_en = ld; load_addr = v[12:0]; wr_step = w; rd_step = r;
        if (rst)     model = 0;
        else if (ld) model = v % 8192;
        else if (w)  model = (model / 32) * 32 + ((model % 32) + 1) % 32;
        else if (r)  model = (model + 1) % 8192;
        it.exp = model[12:0];
        it.req = req;
        q.push_back(it);
    endtask

    initial begin
        drive(1, 0, 0, 0, 0, "R1");
        drive(1, 1, 123, 1, 1, "R1");
        drive(0, 0, 0, 0, 0, "R6");
        drive(0, 0, 0, 0, 1, "R5");
        // Load-only (dummy write), then idle: value persists for the next read.
        drive(0, 1, 13'h0ABC, 0, 0, "R2");
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, "R6");
        drive(0, 0, 0, 0, 1, "R2");
        // Load beats the strobes.
        drive(0, 1, 13'h1555, 1, 0, "R3");
        drive(0, 1, 13'h0777, 0, 1, "R3");
        drive(0, 1, 13'h0010, 1, 1, "R3");
        // Write steps across offset 31 inside page 0x1F0/32.
        drive(0, 1, 13'h1F1D, 0, 0, "R2");
        for (int i = 0; i < 5; i++) drive(0, 0, 0, 1, 0, "R4");
        drive(0, 1, 13'h003F, 0, 0, "R2");
        drive(0, 0, 0, 1, 0, "R8");
        drive(0, 0, 0, 1, 0, "R8");
        // Read steps at the same kind of edge carry into the page.
        drive(0, 1, 13'h003F, 0, 0, "R2");
        drive(0, 0, 0, 0, 1, "R5");
        // Read steps across the top of the array.
        drive(0, 1, 13'h1FFE, 0, 0, "R2");
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, "R5");
        // Both steps together follow the write rule at a page edge.
        drive(0, 1, 13'h1FFF, 0, 0, "R2");
        drive(0, 0, 0, 1, 1, "R7");
        drive(0, 0, 0, 1, 1, "R7");
        drive(0, 0, 0, 0, 0, "R6");
        // A long page sweep returns to the start offset.
        drive(0, 1, 13'h0A47, 0, 0, "R2");
        for (int i = 0; i < 32; i++) drive(0, 0, 0, 1, 0, "R8");
        // Reset in mid-stream.
        drive(0, 0, 0, 0, 1, "R5");
        drive(1, 0, 0, 1, 0, "R1");
        drive(0, 0, 0, 0, 0, "R6");
        @(negedge clk);
        load_en = 0; wr_step = 0; rd_step = 0;
        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog cur_addr=%h expected=finish", cur_addr);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule